// File: doc/BRIEF.md
# Sparse Rotating-Key Syndrome Engine

This block computes the syndrome of a ciphertext against a parity-check matrix made of two circulant blocks. The matrix is never stored in full. Each circulant is kept as a small set of position counters, and each counter names one set bit of the current row. The ciphertext has 2·R bits and is given as two R-bit halves. After a start pulse, the engine steps through bit positions 0 to R-1. At every step it handles one bit of each half at the same time, each half against its own counter set.

When the selected ciphertext bit is one, the syndrome bits that the block's counters point to are inverted. When the bit is zero, the same logic runs with its effect gated off. After each step every counter moves forward by one and wraps back to zero through a compare-and-mask. The run therefore takes the same number of cycles for every key and every ciphertext. Nothing in the run order or timing shows where a counter wraps.

Before a run, software-side logic loads the key positions one counter at a time. When the run ends, the engine raises `done` and holds the R-bit syndrome until the next start. Decoding iterations are handled elsewhere.

Top module: `syndrome_rot_engine`

## Requirements
- R1: While the engine is idle, a cycle with `ld_en` high writes `ld_pos` into counter `ld_idx` of block `ld_blk`. Block 0 serves `ct_lo` and block 1 serves `ct_hi`.
- R2: On each processing step, every counter of both blocks increases by one. A counter holding R-1 becomes 0.
- R3: A 16-bit counter value addresses the syndrome as follows. Bits [15:5] are a 32-bit word number and bits [4:0] a bit within that word. The syndrome bit index is word·32 + bit.
- R4: No counter ever holds a value of R or more, provided only values below R are loaded.
- R5: A start accepted while idle clears the syndrome to zero, drops `done` and raises `busy` on the same clock edge.
- R6: Step j handles ciphertext bit j of each half. If `ct_lo[j]` is 1, the syndrome bit (p + j) mod R is inverted for every block-0 loaded position p. The same holds for `ct_hi[j]` and block 1. A zero bit changes nothing. Two counters at the same position cancel each other.
- R7: `done` rises on the R-th rising edge after the edge that accepts start. It is still low one edge earlier. This holds whatever the ciphertext and key contents are.
- R8: After a complete run, every counter is back at its loaded value. Repeating start with the same ciphertext gives the same syndrome.
- R9: `start` and `ld_en` have no effect while `busy` is high.
- R10: While idle and with no start, `done` and `syndrome` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Counter load strobe (idle only) |
| ld_blk | input | 1 | Block select for the load: 0 or 1 |
| ld_idx | input | IDX_W | Counter number within the block |
| ld_pos | input | 16 | Position value written to the counter |
| ct_lo | input | R | Ciphertext half checked against block 0 |
| ct_hi | input | R | Ciphertext half checked against block 1 |
| start | input | 1 | Begin a syndrome run (idle only) |
| busy | output | 1 | High during the R processing steps |
| done | output | 1 | High from run end until the next accepted start |
| syndrome | output | R | Accumulated syndrome |

## Verification
If start is accepted on edge c, `busy` is high from edge c. The R steps land on edges c+1 through c+R, and `done` and the final syndrome appear on edge c+R. The bench stores each expected syndrome in a queue, tagged with the cycle number of edge c+R. On the falling edge before that cycle it checks that `done` is still low. On the falling edge after it, it compares `done` and the syndrome. Runs with all-zero, all-one and mixed ciphertexts share the same due cycle offset, which checks that timing does not depend on the data. The bench also places a stray load and a stray start during a run; both would move the due cycle or the result if they were acted on.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int CNT_W   = 16;
  localparam int BIT_SEL = 5;

  // Advance one position and fold back to zero through a mask, not a branch.
  function automatic logic [CNT_W-1:0] wrap_step(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] lim);
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] keep;
    inc  = cur + 1'b1;
    keep = {CNT_W{inc < lim}};
    return inc & keep;
  endfunction

  // Word/bit split of a counter into a flat syndrome bit index.
  function automatic int unsigned flat_index(input logic [CNT_W-1:0] c);
    int unsigned word;
    int unsigned bsel;
    word = int'(c[CNT_W-1:BIT_SEL]);
    bsel = int'(c[BIT_SEL-1:0]);
    return word * 32 + bsel;
  endfunction
endpackage

// File: rtl/syn_ctr_bank.sv
module syn_ctr_bank
  import syn_pkg::*;
#(
  parameter int R     = 67,
  parameter int NCNT  = 5,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_we,
  input  logic [IDX_W-1:0]      ld_idx,
  input  logic [CNT_W-1:0]      ld_pos,
  input  logic                  adv,
  output logic [NCNT*CNT_W-1:0] cnt_flat,
  output logic [NCNT-1:0]       wrap_ev
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(R);

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    logic [CNT_W-1:0] c_nxt;
    logic             sel;

    assign c_nxt      = wrap_step(c_q, LIM);
    assign sel        = ld_we && (ld_idx == IDX_W'(k));
    assign wrap_ev[k] = adv && (c_nxt == '0);
    assign cnt_flat[k*CNT_W +: CNT_W] = c_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   c_q <= '0;
      else if (sel) c_q <= ld_pos;
      else if (adv) c_q <= c_nxt;
    end
  end
endmodule

// File: rtl/syn_toggle_gen.sv
module syn_toggle_gen
  import syn_pkg::*;
#(
  parameter int R    = 67,
  parameter int NCNT = 5
) (
  input  logic [NCNT*CNT_W-1:0] cnt_flat,
  input  logic                  bit_en,
  output logic [R-1:0]          tmask
);
  // Every counter is decoded every step; bit_en only gates the result.
  always_comb begin
    tmask = '0;
    for (int k = 0; k < NCNT; k++) begin
      for (int b = 0; b < R; b++) begin
        if (bit_en && (flat_index(cnt_flat[k*CNT_W +: CNT_W]) == b))
          tmask[b] = ~tmask[b];
      end
    end
  end
endmodule

// File: rtl/syn_seq.sv
module syn_seq #(
  parameter int R = 67
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic accept,
  output logic adv,
  output logic last
);
  localparam int POS_W = (R > 1) ? $clog2(R) : 1;

  logic [POS_W-1:0] pos_q;
  logic             busy_q;
  logic             done_q;

  assign accept = start && !busy_q;
  assign adv    = busy_q;
  assign last   = busy_q && (pos_q == POS_W'(R-1));
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pos_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      pos_q  <= '0;
    end else if (busy_q) begin
      pos_q <= pos_q + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/syndrome_rot_engine.sv
module syndrome_rot_engine
  import syn_pkg::*;
#(
  parameter int R      = 67,
  parameter int W_HALF = 5,
  parameter int IDX_W  = (W_HALF > 1) ? $clog2(W_HALF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_blk,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [CNT_W-1:0] ld_pos,
  input  logic [R-1:0]     ct_lo,
  input  logic [R-1:0]     ct_hi,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [R-1:0]     syndrome
);
  localparam int NBLK  = 2;
  localparam int BANKW = W_HALF * CNT_W;

  logic accept, adv, last;
  logic [R-1:0]           synd_q;
  logic [NBLK*BANKW-1:0]  cnt_all;   // named for the checker
  logic [NBLK*W_HALF-1:0] wrap_all;  // per-counter wrap events
  logic [NBLK*R-1:0]      tm_all;
  logic [NBLK-1:0]        bit_now;

  syn_seq #(.R(R)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .accept(accept), .adv(adv), .last(last)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [R-1:0] ct_sh;
    logic         we;

    assign we         = ld_en && !busy && (ld_blk == 1'(b));
    assign bit_now[b] = ct_sh[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ct_sh <= '0;
      else if (accept) ct_sh <= (b == 0) ? ct_lo : ct_hi;
      else if (adv)    ct_sh <= ct_sh >> 1;
    end

    syn_ctr_bank #(.R(R), .NCNT(W_HALF), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .ld_we(we), .ld_idx(ld_idx), .ld_pos(ld_pos),
      .adv(adv),
      .cnt_flat(cnt_all[b*BANKW +: BANKW]),
      .wrap_ev(wrap_all[b*W_HALF +: W_HALF])
    );

    syn_toggle_gen #(.R(R), .NCNT(W_HALF)) u_tog (
      .cnt_flat(cnt_all[b*BANKW +: BANKW]),
      .bit_en(bit_now[b]),
      .tmask(tm_all[b*R +: R])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      synd_q <= '0;
    else if (accept) synd_q <= '0;
    else if (adv)    synd_q <= synd_q ^ tm_all[0 +: R] ^ tm_all[R +: R];
  end

  assign syndrome = synd_q;
endmodule

// File: rtl/syn_engine_chk.sv
module syn_engine_chk
  import syn_pkg::*;
#(
  parameter int R    = 67,
  parameter int NCNT = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [R-1:0]            syndrome,
  input logic [2*NCNT*CNT_W-1:0] cnt_all,
  input logic [2*NCNT-1:0]       wrap_all
);
  int   run_cnt;
  logic all_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= 0;
    else if (start && !busy)   run_cnt <= 0;
    else if (busy)             run_cnt <= run_cnt + 1;
  end

  always_comb begin
    all_in = 1'b1;
    for (int k = 0; k < 2*NCNT; k++)
      if (int'(cnt_all[k*CNT_W +: CNT_W]) >= R) all_in = 1'b0;
  end

  a_r4_ctr_range: assert property (@(posedge clk) disable iff (!rst_n) all_in);

  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> run_cnt == R);

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && syndrome == '0));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(syndrome) && $stable(done)));

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  for (genvar k = 0; k < 2*NCNT; k++) begin : g_wr
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_all[k] |=> cnt_all[k*CNT_W +: CNT_W] == '0);
  end
endmodule

bind syndrome_rot_engine syn_engine_chk #(.R(R), .NCNT(W_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .syndrome(syndrome), .cnt_all(cnt_all), .wrap_all(wrap_all)
);

// File: tb/tb_syndrome_rot_engine.sv
module tb_syndrome_rot_engine;
  localparam int R = 67;
  localparam int W = 5;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, ld_blk = 1'b0, start = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [15:0] ld_pos = '0;
  logic [R-1:0] ct_lo = '0, ct_hi = '0;
  logic busy, done;
  logic [R-1:0] syndrome;

  always #4 clk = ~clk;

  syndrome_rot_engine #(.R(R), .W_HALF(W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_blk(ld_blk), .ld_idx(ld_idx),
    .ld_pos(ld_pos), .ct_lo(ct_lo), .ct_hi(ct_hi), .start(start),
    .busy(busy), .done(done), .syndrome(syndrome)
  );

  typedef struct { logic [R-1:0] s; int due; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  int key[2][W];
  logic [R-1:0] last_exp;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag,
                     input logic [R-1:0] act, input logic [R-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [R-1:0] model(input logic [R-1:0] lo, input logic [R-1:0] hi);
    logic [R-1:0] s = '0;
    for (int j = 0; j < R; j++)
      for (int p = 0; p < W; p++) begin
        if (lo[j]) s[(key[0][p] + j) % R] ^= 1'b1;
        if (hi[j]) s[(key[1][p] + j) % R] ^= 1'b1;
      end
    return s;
  endfunction

  function automatic logic [R-1:0] patt(input int m, input int a);
    logic [R-1:0] v;
    for (int j = 0; j < R; j++) v[j] = ((j * m + a) % 7) < 3;
    return v;
  endfunction

  // Monitor: done must be low one edge before the due cycle and high at it.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      if (cyc == q[0].due - 1) begin
        chk(!done, {"R7 done early ", q[0].tag}, R'(done), '0);
      end else if (cyc == q[0].due) begin
        chk(done, {"R7 done at due ", q[0].tag}, R'(done), R'(1));
        chk(syndrome == q[0].s, {"R6 syndrome ", q[0].tag}, syndrome, q[0].s);
        void'(q.pop_front());
      end
    end
  end

  task automatic load(input int blk, input int idx, input int pos);
    @(negedge clk);
    ld_en = 1'b1; ld_blk = 1'(blk); ld_idx = IDX_W'(idx); ld_pos = 16'(pos);
    key[blk][idx] = pos;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input logic [R-1:0] lo, input logic [R-1:0] hi, input string tag);
    exp_t e;
    ct_lo = lo; ct_hi = hi;
    e.s = model(lo, hi); e.tag = tag;
    @(negedge clk);
    start = 1'b1;
    e.due = cyc + 1 + R;
    q.push_back(e);
    last_exp = e.s;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R5 reset idle", R'({busy, done}), '0);
    chk(syndrome == '0, "R5 reset syndrome", syndrome, '0);
    rst_n = 1'b1;
    // R1/R3: positions span several 32-bit words; R2: R-1 wraps
    load(0, 0, 3);  load(0, 1, 17); load(0, 2, 40); load(0, 3, R-1); load(0, 4, 0);
    load(1, 0, 5);  load(1, 1, 33); load(1, 2, 64); load(1, 3, 21);  load(1, 4, 50);

    run(patt(3, 1), patt(5, 2), "R3 mixed A");
    run('0, '0, "R7 all zero");
    run('1, '1, "R7 all ones");
    run(patt(3, 1), patt(5, 2), "R8 repeat A");
    // R2: last position with counter R-1 lands on R-2
    run(R'(1) << (R-1), '0, "R2 wrap last bit");

    // R6: duplicate position cancels
    load(0, 1, 3);
    run(patt(2, 0), '0, "R6 duplicate cancel");

    // R9: load and start while busy are ignored
    begin
      exp_t e;
      ct_lo = patt(4, 5); ct_hi = patt(6, 1);
      e.s = model(ct_lo, ct_hi); e.tag = "R9 busy ignore";
      @(negedge clk);
      start = 1'b1; e.due = cyc + 1 + R; q.push_back(e); last_exp = e.s;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      ld_en = 1'b1; ld_blk = 1'b0; ld_idx = '0; ld_pos = 16'd9; start = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; start = 1'b0;
      while (q.size() != 0) @(negedge clk);
    end
    run(patt(4, 5), patt(6, 1), "R9 keys unchanged");

    // R10: hold while idle
    repeat (10) @(negedge clk);
    chk(done, "R10 done held", R'(done), R'(1));
    chk(syndrome == last_exp, "R10 syndrome held", syndrome, last_exp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule